// File: doc/BRIEF.md
# Gain-Restoring Stereo Block Transmitter

This block takes one stereo sample pair at a time, each sample paired with a four-bit shift code. It first undoes the analog gain or attenuation that was applied before conversion. Each sample is sign-extended and shifted by its code. Left shifts saturate to the 32-bit signed range, and right shifts are arithmetic. The block then sends the pair to a signal processor as a nine-byte block. The first byte is a channel-source tag. The next four bytes are the 32-bit left word and the last four are the 32-bit right word, each word most significant byte first.

Each byte is presented on `out_byte` together with a one-cycle strobe `out_strobe`. The byte stays valid for the whole strobe cycle, and strobes are `BYTE_CYCLES` clocks apart. A block-start flag `out_first` is high only with the strobe of the source byte. A pair that arrives while a block is still being sent is discarded, and this sets a sticky `overrun` flag. The `tx_mode` input picks the role. When it is high, the block transmits. When it is low, the block is in its receive role: the transmit outputs stay idle, any block in progress is abandoned at once, and incoming pairs are ignored.

Reset is asynchronous and active-low. It is released synchronously inside the block, so the block ignores input pairs for two clocks after `rst_n` rises.

Top module: `stbx_block_tx`

## Requirements
- R1: Block timing. A pair presented with `in_valid` high while `tx_mode` is high and no block is in progress is accepted at that clock edge. Its block then produces exactly nine strobes. The first strobe is in the cycle after acceptance, later strobes follow every `BYTE_CYCLES` clocks, and a new pair is accepted once the block has ended.
- R2: Byte order. Byte 0 is `in_src`. Bytes 1–4 are the restored left word, bits 31:24 first. Bytes 5–8 are the restored right word in the same order.
- R3: Left-shift codes. A code from 0 to 7 shifts the sign-extended sample left by the code value. A result that exceeds the 32-bit signed range saturates to 0x7FFFFFFF when the sample is positive and to 0x80000000 when it is negative.
- R4: Right-shift codes. A code from 8 to 15 shifts the sign-extended sample right arithmetically by (code − 8), so code 8 passes the sample through unchanged.
- R5: `out_first` is high only in the strobe cycle of byte 0, and low for the other eight strobes and for every cycle without a strobe.
- R6: `out_strobe` lasts one clock per byte. `out_byte` holds the byte for the whole strobe cycle and reads 0x00 in every cycle without a strobe.
- R7: Receive role. While `tx_mode` is low, `out_strobe` and `out_first` are low and `in_valid` is ignored: no block starts and `overrun` does not change.
- R8: Overrun. A pair with `in_valid` high while a block is in progress and `tx_mode` is high is dropped, the block continues unchanged, and `overrun` goes high. `overrun` stays high until reset.
- R9: Abandon. When `tx_mode` goes low during a block, strobes stop in that same cycle and the rest of that block is never sent.
- R10: Reset state. While `rst_n` is low, `out_strobe`, `out_first`, `out_byte` and `overrun` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_mode | input | 1 | 1 = transmit role, 0 = receive role (outputs idle) |
| in_valid | input | 1 | One-cycle marker of a new sample pair |
| in_src | input | 8 | Channel-source tag sent as byte 0 |
| in_left | input | SAMPLE_W | Left sample, two's complement |
| in_left_code | input | 4 | Left shift code (0–7 left, 8–15 right by code−8) |
| in_right | input | SAMPLE_W | Right sample, two's complement |
| in_right_code | input | 4 | Right shift code |
| out_byte | output | 8 | Byte being sent, zero outside strobes |
| out_strobe | output | 1 | One-clock byte strobe |
| out_first | output | 1 | High with the strobe of byte 0 only |
| overrun | output | 1 | Sticky flag for a dropped pair |

## Verification
The bench goes after several corner cases, each paired with the failure it would expose:
- Saturation at both extremes of the left shift. A design without the range check would wrap the word and flip its sign.
- Code 15 applied to a negative sample. A logical shift would clear the upper bits instead of filling them with ones.
- A pair offered in the last cycle of a block. This catches an off-by-one that would start a new block early.
- A pair offered one cycle after the block ends. This catches an off-by-one that would drop the pair.
- A role change in the middle of a block, checked by the exact count of strobes sent. A design that finishes the block anyway would show extra strobes.
- A pair offered in the receive role. A design that failed to ignore it would start a block or raise `overrun`.
- Reset after an overrun. `overrun` must clear on reset and stay set otherwise.

// File: rtl/stbx_pkg.sv
package stbx_pkg;
  localparam int BYTE_W     = 8;
  localparam int MAX_LSHIFT = 7;
  localparam int CODE_W     = 4;
  typedef logic [CODE_W-1:0] shift_code_t;
endpackage

// File: rtl/stbx_reset_sync.sv
module stbx_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) chain_q <= '0;
    else          chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = chain_q[STAGES-1];
endmodule

// File: rtl/stbx_gain_shift.sv
module stbx_gain_shift
  import stbx_pkg::*;
#(
  parameter int SAMPLE_W = 32,
  parameter int WORD_W   = 32
) (
  input  logic [SAMPLE_W-1:0] sample_i,
  input  shift_code_t         code_i,
  output logic [WORD_W-1:0]   word_o
);
  localparam int EXT_W = WORD_W + MAX_LSHIFT;
  localparam int HI_W  = EXT_W - WORD_W + 1;

  logic signed [EXT_W-1:0] ext;
  logic signed [EXT_W-1:0] up;
  logic signed [EXT_W-1:0] down;
  logic [HI_W-1:0]         hi_bits;
  logic                    fits;

  always_comb begin
    ext     = {{(EXT_W-SAMPLE_W){sample_i[SAMPLE_W-1]}}, sample_i};
    up      = ext <<< code_i[2:0];
    down    = ext >>> code_i[2:0];
    hi_bits = up[EXT_W-1:WORD_W-1];
    fits    = (hi_bits == '0) || (&hi_bits);
    if (code_i[3])      word_o = down[WORD_W-1:0];
    else if (fits)      word_o = up[WORD_W-1:0];
    else if (ext[EXT_W-1]) word_o = {1'b1, {(WORD_W-1){1'b0}}};
    else                word_o = {1'b0, {(WORD_W-1){1'b1}}};
  end
endmodule

// File: rtl/stbx_sequencer.sv
module stbx_sequencer #(
  parameter int BLOCK_BYTES = 9,
  parameter int BYTE_CYCLES = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          tx_mode,
  input  logic                          in_valid,
  output logic                          accept,
  output logic                          busy,
  output logic                          strobe,
  output logic                          first,
  output logic [$clog2(BLOCK_BYTES)-1:0] byte_idx,
  output logic                          overrun
);
  localparam int IDX_W   = $clog2(BLOCK_BYTES);
  localparam int PHASE_W = (BYTE_CYCLES > 1) ? $clog2(BYTE_CYCLES) : 1;
  localparam logic [IDX_W-1:0]   LAST_IDX   = IDX_W'(BLOCK_BYTES - 1);
  localparam logic [PHASE_W-1:0] LAST_PHASE = PHASE_W'(BYTE_CYCLES - 1);

  logic               busy_q, busy_d;
  logic [IDX_W-1:0]   idx_q, idx_d;
  logic [PHASE_W-1:0] phase_q, phase_d;
  logic               ovr_q, ovr_d;
  logic               drop, last_phase, last_byte;

  always_comb begin
    accept     = in_valid && tx_mode && !busy_q;
    drop       = in_valid && tx_mode && busy_q;
    last_phase = (phase_q == LAST_PHASE);
    last_byte  = (idx_q == LAST_IDX);

    busy_d  = busy_q;
    idx_d   = idx_q;
    phase_d = phase_q;
    ovr_d   = ovr_q || drop;

    if (!tx_mode) begin
      busy_d  = 1'b0;
      idx_d   = '0;
      phase_d = '0;
    end else if (accept) begin
      busy_d  = 1'b1;
      idx_d   = '0;
      phase_d = '0;
    end else if (busy_q) begin
      if (last_phase) begin
        phase_d = '0;
        if (last_byte) begin
          busy_d = 1'b0;
          idx_d  = '0;
        end else begin
          idx_d = idx_q + 1'b1;
        end
      end else begin
        phase_d = phase_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      idx_q   <= '0;
      phase_q <= '0;
      ovr_q   <= 1'b0;
    end else begin
      busy_q  <= busy_d;
      idx_q   <= idx_d;
      phase_q <= phase_d;
      ovr_q   <= ovr_d;
    end
  end

  assign busy     = busy_q;
  assign strobe   = tx_mode && busy_q && (phase_q == '0);
  assign first    = strobe && (idx_q == '0);
  assign byte_idx = idx_q;
  assign overrun  = ovr_q;
endmodule

// File: rtl/stbx_block_tx.sv
module stbx_block_tx
  import stbx_pkg::*;
#(
  parameter int SAMPLE_W    = 32,
  parameter int WORD_W      = 32,
  parameter int BYTE_CYCLES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tx_mode,
  input  logic                in_valid,
  input  logic [7:0]          in_src,
  input  logic [SAMPLE_W-1:0] in_left,
  input  logic [3:0]          in_left_code,
  input  logic [SAMPLE_W-1:0] in_right,
  input  logic [3:0]          in_right_code,
  output logic [7:0]          out_byte,
  output logic                out_strobe,
  output logic                out_first,
  output logic                overrun
);
  localparam int BLOCK_BYTES = 1 + 2 * (WORD_W / BYTE_W);
  localparam int BLK_W       = BYTE_W * BLOCK_BYTES;
  localparam int IDX_W       = $clog2(BLOCK_BYTES);

  logic                rst_sync_n;
  logic                accept, busy, strobe, first;
  logic [IDX_W-1:0]    byte_idx;
  logic [SAMPLE_W-1:0] samples [2];
  shift_code_t         codes   [2];
  logic [WORD_W-1:0]   words   [2];
  logic [BLK_W-1:0]    block_q, block_d;
  logic [BYTE_W-1:0]   slots   [BLOCK_BYTES];

  stbx_reset_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n_i(rst_n), .rst_n_o(rst_sync_n)
  );

  assign samples[0] = in_left;
  assign samples[1] = in_right;
  assign codes[0]   = in_left_code;
  assign codes[1]   = in_right_code;

  for (genvar g = 0; g < 2; g++) begin : g_chan
    stbx_gain_shift #(.SAMPLE_W(SAMPLE_W), .WORD_W(WORD_W)) u_shift (
      .sample_i(samples[g]), .code_i(codes[g]), .word_o(words[g])
    );
  end

  stbx_sequencer #(.BLOCK_BYTES(BLOCK_BYTES), .BYTE_CYCLES(BYTE_CYCLES)) u_seq (
    .clk(clk), .rst_n(rst_sync_n), .tx_mode(tx_mode), .in_valid(in_valid),
    .accept(accept), .busy(busy), .strobe(strobe), .first(first),
    .byte_idx(byte_idx), .overrun(overrun)
  );

  always_comb begin
    block_d = block_q;
    if (accept) block_d = {in_src, words[0], words[1]};
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) block_q <= '0;
    else             block_q <= block_d;
  end

  for (genvar k = 0; k < BLOCK_BYTES; k++) begin : g_slot
    assign slots[k] = block_q[BLK_W-1-BYTE_W*k -: BYTE_W];
  end

  assign out_byte   = strobe ? slots[byte_idx] : '0;
  assign out_strobe = strobe;
  assign out_first  = first;
endmodule

// File: rtl/stbx_block_tx_chk.sv
module stbx_block_tx_chk #(
  parameter int BYTE_CYCLES = 2
) (
  input logic       clk,
  input logic       rst_n,
  input logic       tx_mode,
  input logic       in_valid,
  input logic       busy,
  input logic [7:0] out_byte,
  input logic       out_strobe,
  input logic       out_first,
  input logic       overrun
);
  // R1, R5: an accepted pair shows its source byte in the next cycle
  assert_start_next_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_mode && in_valid && !busy) |=> (out_first || !tx_mode));

  assert_first_on_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_first |-> out_strobe);

  assert_byte_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !out_strobe |-> (out_byte == 8'h00));

  assert_rx_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_mode |-> (!out_strobe && !out_first));

  assert_drop_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_mode && in_valid && busy) |=> overrun);

  assert_overrun_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);

  assert_abandon_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_mode |=> !busy);

  if (BYTE_CYCLES > 1) begin : g_gap
    assert_strobe_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
      out_strobe |=> !out_strobe);
  end
endmodule

bind stbx_block_tx stbx_block_tx_chk #(.BYTE_CYCLES(BYTE_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .tx_mode(tx_mode), .in_valid(in_valid),
  .busy(busy), .out_byte(out_byte), .out_strobe(out_strobe),
  .out_first(out_first), .overrun(overrun)
);

// File: tb/test_stbx_block_tx.sv
module test_stbx_block_tx;
  localparam int CLK_PERIOD = 10;
  localparam int BYTE_P     = 2;
  localparam int NBYTES     = 9;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tx_mode = 1'b0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_src = '0;
  logic [31:0] in_left = '0, in_right = '0;
  logic [3:0]  in_left_code = '0, in_right_code = '0;
  logic [7:0]  out_byte;
  logic        out_strobe, out_first, overrun;

  int n_tests = 0;
  int n_fail  = 0;
  int n_strobes = 0;
  logic [7:0] rx_q[$];

  stbx_block_tx #(.SAMPLE_W(32), .WORD_W(32), .BYTE_CYCLES(BYTE_P)) i_stbx_block_tx (
    .clk(clk), .rst_n(rst_n), .tx_mode(tx_mode), .in_valid(in_valid),
    .in_src(in_src), .in_left(in_left), .in_left_code(in_left_code),
    .in_right(in_right), .in_right_code(in_right_code),
    .out_byte(out_byte), .out_strobe(out_strobe), .out_first(out_first),
    .overrun(overrun)
  );

  initial forever #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] restore(logic [31:0] s, logic [3:0] code);
    longint v = longint'($signed(s));
    if (code < 8) v = v * (longint'(1) << code);
    else          v = v >>> (code - 8);
    if (v > 64'sd2147483647)  v = 64'sd2147483647;
    if (v < -64'sd2147483648) v = -64'sd2147483648;
    return v[31:0];
  endfunction

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", what, act, exp, $time);
    end
  endtask

  // behavioural reference model
  bit         m_act = 0;
  int         m_pos = 0;
  bit         m_ovr = 0;
  logic [7:0] m_bytes[NBYTES];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_act = 0; m_pos = 0; m_ovr = 0;
    end else if (!tx_mode) begin
      m_act = 0;
    end else if (m_act) begin
      if (in_valid) m_ovr = 1;
      m_pos++;
      if (m_pos == NBYTES * BYTE_P) m_act = 0;
    end else if (in_valid) begin
      logic [31:0] lw, rw;
      lw = restore(in_left, in_left_code);
      rw = restore(in_right, in_right_code);
      m_bytes[0] = in_src;
      for (int i = 0; i < 4; i++) begin
        m_bytes[1+i] = lw[31-8*i -: 8];
        m_bytes[5+i] = rw[31-8*i -: 8];
      end
      m_act = 1; m_pos = 0;
    end
  end

  always @(negedge clk) begin
    logic es, ef;
    logic [7:0] eb;
    es = tx_mode && m_act && (m_pos % BYTE_P == 0);
    ef = es && (m_pos == 0);
    eb = es ? m_bytes[m_pos / BYTE_P] : 8'h00;
    chk("R1 R6 R7 R9 strobe", 32'(out_strobe), 32'(es));
    chk("R5 first flag", 32'(out_first), 32'(ef));
    chk("R2 R3 R4 R6 byte", 32'(out_byte), 32'(eb));
    chk("R8 overrun", 32'(overrun), 32'(m_ovr));
    if (out_strobe) begin
      n_strobes++;
      rx_q.push_back(out_byte);
    end
  end

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic send(logic [7:0] s, logic [31:0] l, logic [3:0] lc,
                      logic [31:0] r, logic [3:0] rc);
    in_src = s; in_left = l; in_left_code = lc; in_right = r; in_right_code = rc;
    in_valid = 1'b1;
    tick(1);
    in_valid = 1'b0;
  endtask

  function automatic logic [31:0] rx_word(int at);
    return {rx_q[at], rx_q[at+1], rx_q[at+2], rx_q[at+3]};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog R1 actual=timeout expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int base;
    tick(2);
    @(negedge clk);
    chk("R10 reset strobe", 32'(out_strobe), 0);
    chk("R10 reset byte", 32'(out_byte), 0);
    chk("R10 reset overrun", 32'(overrun), 0);
    tick(1);
    rst_n = 1'b1;
    tick(4);

    // plain block
    tx_mode = 1'b1;
    rx_q.delete(); base = n_strobes;
    send(8'hA5, 32'h0000_0123, 4'd0, 32'hFFFF_FF00, 4'd0);
    tick(22);
    chk("R1 strobe count", 32'(n_strobes - base), 9);
    chk("R2 source byte", 32'(rx_q[0]), 32'hA5);
    chk("R2 left word", rx_word(1), 32'h0000_0123);
    chk("R2 right word", rx_word(5), 32'hFFFF_FF00);

    // saturation
    rx_q.delete();
    send(8'h3C, 32'h4000_0000, 4'd1, 32'hC000_0000, 4'd3);
    tick(22);
    chk("R3 positive saturation", rx_word(1), 32'h7FFF_FFFF);
    chk("R3 negative saturation", rx_word(5), 32'h8000_0000);

    // right shifts
    rx_q.delete();
    send(8'h01, 32'h8000_0001, 4'd15, 32'h0000_1000, 4'd12);
    tick(22);
    chk("R4 arithmetic right", rx_word(1), 32'hFF00_0000);
    chk("R4 right by four", rx_word(5), 32'h0000_0100);

    // overrun
    rx_q.delete(); base = n_strobes;
    send(8'h22, 32'h1234_5678, 4'd8, 32'h0000_0007, 4'd4);
    tick(4);
    send(8'h99, 32'h1, 4'd0, 32'h2, 4'd0);
    tick(20);
    chk("R8 overrun set", 32'(overrun), 1);
    chk("R8 dropped pair sends nothing", 32'(n_strobes - base), 9);
    chk("R8 block continues", 32'(rx_q[0]), 32'h22);

    // receive role ignores pairs
    tx_mode = 1'b0;
    base = n_strobes;
    send(8'h55, 32'h5, 4'd0, 32'h6, 4'd0);
    tick(20);
    chk("R7 no strobes in receive", 32'(n_strobes - base), 0);

    // reset clears overrun
    rst_n = 1'b0;
    tick(1);
    chk("R8 R10 overrun cleared", 32'(overrun), 0);
    rst_n = 1'b1;
    tick(4);

    // abandon mid-block
    tx_mode = 1'b1;
    base = n_strobes;
    send(8'h77, 32'h7, 4'd0, 32'h8, 4'd0);
    tick(5);
    tx_mode = 1'b0;
    tick(20);
    chk("R9 strobes before abandon", 32'(n_strobes - base), 3);

    // back-to-back edges
    tx_mode = 1'b1;
    base = n_strobes;
    send(8'h10, 32'h10, 4'd0, 32'h11, 4'd0);
    tick(18);
    send(8'h20, 32'h20, 4'd0, 32'h21, 4'd0);
    tick(22);
    chk("R1 next pair accepted after end", 32'(n_strobes - base), 18);
    chk("R1 R8 no overrun at boundary", 32'(overrun), 0);
    base = n_strobes;
    send(8'h30, 32'h30, 4'd0, 32'h31, 4'd0);
    tick(17);
    send(8'h40, 32'h40, 4'd0, 32'h41, 4'd0);
    tick(22);
    chk("R1 R8 last-cycle pair dropped", 32'(n_strobes - base), 9);
    chk("R8 last-cycle overrun", 32'(overrun), 1);

    // random traffic, model compares every cycle
    for (int it = 0; it < 40; it++) begin
      send(8'($urandom), $urandom, 4'($urandom), $urandom, 4'($urandom));
      tick(int'($urandom_range(0, 24)));
    end
    tick(30);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule